// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands of WIDTH bits each and returns their product of 2*WIDTH bits. A one-cycle pulse on `load` captures both operands. The multiplicand goes into an internal holding register. The multiplier goes into the low half of the product register, and the high half of that register is cleared. The operand buses are then no longer read.

The unit then runs WIDTH add-and-shift iterations, and each iteration takes exactly two clock cycles. The first cycle of an iteration is the add. When bit 0 of the product register is 1, the held multiplicand is added into the upper half; when it is 0, nothing is added. The second cycle shifts the whole register right by one place and moves the carry of the add into the top bit. The register therefore holds the growing partial product in its upper bits and the multiplier bits not yet used in its lower bits.

The latency is fixed at 2*WIDTH cycles. `done` pulses for one cycle when the result is complete, and the result then stays unchanged until the next load.

Top module: `shiftadd_mul`

## Requirements
- R1: In the cycle after a cycle with `load` high, `product[2*WIDTH-1:WIDTH]` is zero, `product[WIDTH-1:0]` equals the `opb` value that was sampled, and `done` is low.
- R2: Only the `opa` and `opb` values sampled in the load cycle affect the result. Changing the operand buses after the load does not change the product.
- R3: Exactly 2*WIDTH clock edges after the load edge, `product` equals opa*opb, both taken as unsigned.
- R4: `done` is high only in the cycle that follows the 2*WIDTH-th edge after the load edge, and it stays high for that one cycle only.
- R5: After i completed iterations (2*i edges after the load edge, with 0 < i < WIDTH), `product >> (WIDTH-i)` equals opa*(opb mod 2^i), and `product mod 2^(WIDTH-i)` equals opb >> i.
- R6: On the add cycle of an iteration, if `product[0]` is 0, `product` is left unchanged.
- R7: While no multiplication is running and `load` is low, `product` holds its value. This covers the whole time after `done`, up to the next load.
- R8: A `load` during a running multiplication aborts it and restarts with the new operands. This includes a load on the final shift cycle; in that case `done` is not raised and R1 applies.
- R9: A synchronous active-high `rst` clears `product` and `done` on the next edge, including in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle start pulse that captures both operands |
| opa | input | WIDTH | Multiplicand operand |
| opb | input | WIDTH | Multiplier operand |
| product | output | 2*WIDTH | Product register: partial product plus unused multiplier bits |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
A new load and the completion of the final iteration can fall on the same clock edge. The bench provokes this by raising `load` exactly 2*WIDTH-1 cycles after a previous load, so that the load is sampled on the final shift edge. The expected outcome is that the restart wins: `done` stays low, the product register shows the freshly loaded operand, and the scoreboard receives only the second result after a further 2*WIDTH cycles. An abort early in a run and a reset in the middle of a run are judged the same way, against the scoreboard's queue.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic {
    PH_ADD   = 1'b0,
    PH_SHIFT = 1'b1
  } phase_t;
endpackage

// File: rtl/smul_adder.sv
module smul_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] acc,
  input  logic [N-1:0] addend,
  input  logic         en,
  output logic [N:0]   sum
);
  always_comb begin
    sum = {1'b0, acc} + (en ? {1'b0, addend} : {(N+1){1'b0}});
  end
endmodule

// File: rtl/smul_seq.sv
module smul_seq
  import smul_pkg::*;
#(
  parameter int N = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  output logic   busy,
  output phase_t phase,
  output logic   do_add,
  output logic   do_shift,
  output logic   done
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] iter_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      phase  <= PH_ADD;
      iter_q <= '0;
      done   <= 1'b0;
    end else if (load) begin
      busy   <= 1'b1;
      phase  <= PH_ADD;
      iter_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        if (phase == PH_ADD) begin
          phase <= PH_SHIFT;
        end else begin
          phase <= PH_ADD;
          if (iter_q == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            iter_q <= iter_q + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    do_add   = busy && !load && (phase == PH_ADD);
    do_shift = busy && !load && (phase == PH_SHIFT);
  end
endmodule

// File: rtl/smul_dp.sv
module smul_dp #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [N-1:0] a_in,
  input  logic [N-1:0] b_in,
  input  logic         do_add,
  input  logic         do_shift,
  output logic [2*N-1:0] prod
);
  localparam int PW = 2 * N;

  logic [N-1:0] mcand_q;
  logic         carry_q;
  logic [N:0]   sum;

  smul_adder #(.N(N)) u_add (
    .acc    (prod[PW-1:N]),
    .addend (mcand_q),
    .en     (prod[0]),
    .sum    (sum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      carry_q <= 1'b0;
      prod    <= '0;
    end else if (load) begin
      mcand_q <= a_in;
      carry_q <= 1'b0;
      prod    <= {{N{1'b0}}, b_in};
    end else if (do_add) begin
      prod[PW-1:N] <= sum[N-1:0];
      carry_q      <= sum[N];
    end else if (do_shift) begin
      prod    <= {carry_q, prod[PW-1:1]};
      carry_q <= 1'b0;
    end
  end
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
  import smul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [WIDTH-1:0]   opa,
  input  logic [WIDTH-1:0]   opb,
  output logic [2*WIDTH-1:0] product,
  output logic               done
);
  logic   busy;
  phase_t phase;
  logic   do_add;
  logic   do_shift;

  smul_seq #(.N(WIDTH)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .busy     (busy),
    .phase    (phase),
    .do_add   (do_add),
    .do_shift (do_shift),
    .done     (done)
  );

  smul_dp #(.N(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .a_in     (opa),
    .b_in     (opb),
    .do_add   (do_add),
    .do_shift (do_shift),
    .prod     (product)
  );
endmodule

// File: rtl/smul_chk.sv
module smul_chk
  import smul_pkg::*;
#(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           load,
  input logic [N-1:0]   opb,
  input logic [2*N-1:0] product,
  input logic           done,
  input logic           busy,
  input phase_t         phase
);
  localparam int LAT = 2 * N;
  localparam int KW  = $clog2(LAT + 1) + 1;

  logic          armed;
  logic [KW-1:0] since_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b0;
      since_load <= '0;
    end else if (load) begin
      armed      <= 1'b1;
      since_load <= '0;
    end else if (armed && since_load != KW'(LAT + 1)) begin
      since_load <= since_load + 1'b1;
    end
  end

  assert_load_init_R1: assert property (@(posedge clk) disable iff (rst)
    load |=> (product == {{N{1'b0}}, $past(opb)}) && !done);

  assert_done_latency_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (armed && since_load == KW'(LAT)));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_zero_add_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !load && phase == PH_ADD && !product[0]) |=> $stable(product));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> $stable(product));
endmodule

bind shiftadd_mul smul_chk #(.N(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load    (load),
  .opb     (opb),
  .product (product),
  .done    (done),
  .busy    (busy),
  .phase   (phase)
);

// File: tb/shiftadd_mul_tb.sv
module shiftadd_mul_tb;
  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst;
  logic          load;
  logic [N-1:0]  opa, opb;
  logic [PW-1:0] product;
  logic          done;

  int checks = 0;
  int fails  = 0;
  logic [PW-1:0] expq[$];

  always #10 clk = ~clk;

  shiftadd_mul #(.WIDTH(N)) u_dut (
    .clk(clk), .rst(rst), .load(load), .opa(opa), .opb(opb),
    .product(product), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: each done pulse pops one expected product from the scoreboard.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected done", product, '0);
      end else begin
        logic [PW-1:0] e;
        e = expq.pop_front();
        chk(product == e, "R3 scoreboard", product, e);
      end
    end
  end

  // Driver: called at a negedge; returns at the negedge after the load edge.
  task automatic launch(input logic [N-1:0] a, input logic [N-1:0] b, input bit push);
    opa  = a;
    opb  = b;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    opa  = N'($urandom);
    opb  = N'($urandom);  // R2: buses scrambled after capture
    if (push) expq.push_back(PW'(a) * PW'(b));
  endtask

  task automatic follow(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [PW-1:0] prev;
    logic [PW-1:0] full;
    full = PW'(a) * PW'(b);
    chk(product == {{N{1'b0}}, b} && !done, "R1 load state", product, {{N{1'b0}}, b});
    for (int i = 1; i <= N; i++) begin
      prev = product;
      @(negedge clk);
      if (!prev[0]) chk(product == prev, "R6 zero add", product, prev);
      chk(!done, "R4 early done", PW'(done), '0);
      @(negedge clk);
      if (i < N) begin
        logic [PW-1:0] hi_e, lo_e;
        hi_e = PW'(a) * (PW'(b) & ((PW'(1) << i) - 1));
        lo_e = PW'(b) >> i;
        chk((product >> (N - i)) == hi_e, "R5 partial upper", product >> (N - i), hi_e);
        chk((product & ((PW'(1) << (N - i)) - 1)) == lo_e, "R5 remaining bits",
            product & ((PW'(1) << (N - i)) - 1), lo_e);
        chk(!done, "R4 early done", PW'(done), '0);
      end else begin
        chk(done == 1'b1, "R4 done at 2N", PW'(done), PW'(1));
        chk(product == full, "R3 R2 final product", product, full);
      end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!done, "R4 done one cycle", PW'(done), '0);
      chk(product == full, "R7 hold after done", product, full);
    end
  endtask

  task automatic run_full(input logic [N-1:0] a, input logic [N-1:0] b);
    launch(a, b, 1'b1);
    follow(a, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; load = 1'b0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(product == '0 && !done, "R9 reset state", product, '0);
    @(negedge clk);
    chk(product == '0, "R7 idle hold", product, '0);

    run_full(8'd13, 8'd11);
    run_full(8'd0, 8'd255);
    run_full(8'd255, 8'd255);
    run_full(8'd1, 8'd128);
    run_full(8'd170, 8'd85);
    for (int t = 0; t < 6; t++) run_full(N'($urandom), N'($urandom));

    // R8: abort early in a run
    launch(8'd200, 8'd77, 1'b0);
    repeat (5) @(negedge clk);
    run_full(8'd37, 8'd99);

    // R8: load coincides with the final shift edge
    launch(8'd99, 8'd201, 1'b0);
    repeat (PW - 1) @(negedge clk);
    launch(8'd45, 8'd6, 1'b1);
    chk(!done, "R8 collision suppresses done", PW'(done), '0);
    follow(8'd45, 8'd6);

    // R9: reset in mid run
    launch(8'd250, 8'd250, 1'b0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(product == '0 && !done, "R9 mid-run reset", product, '0);
    repeat (PW + 2) @(negedge clk);
    chk(product == '0 && !done, "R9 R7 stays clear", product, '0);

    run_full(8'd7, 8'd9);
    chk(expq.size() == 0, "R3 scoreboard drained", PW'(expq.size()), '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule